// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor

This block is a small processor that knows exactly one instruction. Each instruction is three consecutive 16-bit words in a 256-word internal memory: a source address `a`, a destination address `b` and a branch target. The instruction first forms `Mem[b] - Mem[a]`. It then stores that difference back into location `b`. If the stored value is zero or negative, the program counter moves to the target. Otherwise the program counter moves to the next instruction, three words further on. Programs and data share the same memory, so a program can rewrite its own operand words.

Memory is loaded through a write port while the core is held in reset. When reset is released, execution starts at address 0. Each instruction takes six clock cycles on the single-ported memory, which has a synchronous read. A taken branch whose target has its top bit set stops the core and raises a sticky halt flag. Every write-back is shown on a commit strobe with its address and value, so the surrounding logic can observe progress.

Top module: `subneg_cpu`

## Requirements
- R1: While `rst` is high, a pulse on `load_we` writes `load_data` to `load_addr`. Reset forces `pc_o` to 0, `halted` to 0 and `commit_en` to 0. After release, the first instruction is fetched from address 0.
- R2: An instruction takes exactly six cycles, counted from the first cycle after reset release or from the cycle after the previous commit. `commit_en` is high only in the sixth cycle, and never in two consecutive cycles.
- R3: In the commit cycle, `commit_addr` is the low 8 bits of word `pc+1`, and `commit_data` is `Mem[b] - Mem[a]` modulo 2^16 (for example 0x8000 - 1 = 0x7FFF). That value is written to location `b`.
- R4: If the result is zero or negative as a signed 16-bit number, the next `pc_o` is the low 8 bits of the target word (word `pc+2`).
- R5: If the result is strictly positive, the next `pc_o` is `pc_o + 3` modulo 256, whatever the target word holds, including targets with bit 15 set.
- R6: An instruction with `a == b` writes 0 to that location and takes the branch.
- R7: A taken branch whose target has bit 15 set still performs its write. It then sets `halted`, which stays high until reset. `pc_o` keeps the halting instruction's address, and no further commit occurs.
- R8: A value written by one instruction is the value that any later fetch or operand read of that location returns.
- R9: `load_we` has no effect while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; enables the load port |
| load_we | input | 1 | Load-port write strobe (honoured only in reset) |
| load_addr | input | 8 | Load-port word address |
| load_data | input | 16 | Load-port word value |
| pc_o | output | 8 | Address of the instruction being executed |
| halted | output | 1 | Sticky stop flag |
| commit_en | output | 1 | High in the write-back cycle |
| commit_addr | output | 8 | Location written in that cycle |
| commit_data | output | 16 | Value written in that cycle |

## Verification
The bench aims at the sign boundary of the result. A result of exactly zero must branch. A design that tests only for negative values would fall through there and skip a loop exit. A result that wraps from 0x8000 to 0x7FFF is positive and must fall through. A design that compares with a wide signed subtraction would branch instead.

A target with bit 15 set is placed behind a positive result, where it must not stop the core. The same kind of target is also placed behind taken branches, where it must. A design that decodes the halt bit without looking at the branch outcome stops early.

One instruction rewrites the target word of the next instruction, which catches stale operand registers or a late write. Load-port pulses during execution catch a write port that is not gated by reset.

// File: rtl/subneg_cpu.sv
module subneg_cpu #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [AW-1:0] pc_o,
  output logic          halted,
  output logic          commit_en,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    S_FA, S_FB, S_FT, S_RA, S_RB, S_WB, S_HALT
  } state_t;

  state_t        state;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata;
  logic [AW-1:0] raddr;
  logic [AW-1:0] pc, src_a, dst_b, tgt;
  logic          tgt_stop;
  logic [DW-1:0] val_a;
  logic [DW-1:0] diff;
  logic          take;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  assign diff = rdata - val_a;
  assign take = diff[DW-1] | (diff == '0);

  assign commit_en   = (state == S_WB);
  assign commit_addr = dst_b;
  assign commit_data = diff;
  assign pc_o        = pc;

  assign we    = rst ? load_we   : commit_en;
  assign waddr = rst ? load_addr : dst_b;
  assign wdata = rst ? load_data : diff;

  always_comb begin
    case (state)
      S_FA:    raddr = pc;
      S_FB:    raddr = pc + AW'(1);
      S_FT:    raddr = pc + AW'(2);
      S_RA:    raddr = src_a;
      S_RB:    raddr = dst_b;
      default: raddr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FA;
      pc       <= '0;
      halted   <= 1'b0;
      src_a    <= '0;
      dst_b    <= '0;
      tgt      <= '0;
      tgt_stop <= 1'b0;
      val_a    <= '0;
    end else begin
      case (state)
        S_FA: state <= S_FB;
        S_FB: begin
          src_a <= rdata[AW-1:0];
          state <= S_FT;
        end
        S_FT: begin
          dst_b <= rdata[AW-1:0];
          state <= S_RA;
        end
        S_RA: begin
          tgt      <= rdata[AW-1:0];
          tgt_stop <= rdata[DW-1];
          state    <= S_RB;
        end
        S_RB: begin
          val_a <= rdata;
          state <= S_WB;
        end
        S_WB: begin
          if (take && tgt_stop) begin
            halted <= 1'b1;
            state  <= S_HALT;
          end else begin
            pc    <= take ? tgt : pc + AW'(3);
            state <= S_FA;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/subneg_cpu_chk.sv
module subneg_cpu_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pc_o,
  input logic          halted,
  input logic          commit_en,
  input logic [DW-1:0] commit_data
);
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r7_no_commit_when_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !commit_en);

  a_r2_commit_single_cycle: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> !commit_en);

  a_r2_pc_only_moves_on_commit: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(pc_o));

  a_r5_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (commit_en && !commit_data[DW-1] && commit_data != '0) |=>
      (pc_o == AW'($past(pc_o) + AW'(3))));

  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_o == '0 && !halted && !commit_en));
endmodule

bind subneg_cpu subneg_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pc_o(pc_o), .halted(halted),
  .commit_en(commit_en), .commit_data(commit_data)
);

// File: tb/test_subneg_cpu.sv
module test_subneg_cpu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [7:0]  pc_o;
  logic        halted;
  logic        commit_en;
  logic [7:0]  commit_addr;
  logic [15:0] commit_data;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_mem [256];
  logic [7:0]  m_pc;
  logic        m_halted;
  int          m_phase;
  string       last_pc_tag;
  int          n_commits;

  subneg_cpu i_subneg_cpu (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .pc_o(pc_o), .halted(halted),
    .commit_en(commit_en), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [15:0] val);
    m_mem[addr] = val;
    @(negedge clk);
    load_we = 1'b1; load_addr = 8'(addr); load_data = val;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic put_ins(input int addr, input int a, input int b, input logic [15:0] t);
    put(addr, 16'(a)); put(addr + 1, 16'(b)); put(addr + 2, t);
  endtask

  task automatic compare();
    logic [7:0]  a, b;
    logic [15:0] t, d;
    bit          exp_c;
    exp_c = (m_phase == 5) && !m_halted;
    check("R2 commit_en", commit_en, exp_c);
    check("R7 halted", halted, m_halted);
    check({last_pc_tag, " pc"}, pc_o, m_pc);
    if (exp_c && commit_en) begin
      a = m_mem[m_pc][7:0];
      b = m_mem[8'(m_pc + 8'd1)][7:0];
      t = m_mem[8'(m_pc + 8'd2)];
      d = m_mem[b] - m_mem[a];
      check("R3 commit_addr", commit_addr, b);
      check((a == b) ? "R6 clear" : "R3 diff", commit_data, d);
    end
  endtask

  task automatic step();
    logic [7:0]  a, b;
    logic [15:0] t, d;
    bit          tk;
    if (m_halted) return;
    if (m_phase < 5) begin
      m_phase++;
      return;
    end
    m_phase = 0;
    n_commits++;
    a = m_mem[m_pc][7:0];
    b = m_mem[8'(m_pc + 8'd1)][7:0];
    t = m_mem[8'(m_pc + 8'd2)];
    d = m_mem[b] - m_mem[a];
    m_mem[b] = d;
    tk = d[15] || (d == 16'd0);
    if (tk && t[15]) m_halted = 1'b1;
    else if (tk) begin m_pc = t[7:0]; last_pc_tag = "R4"; end
    else begin m_pc = m_pc + 8'd3; last_pc_tag = "R5"; end
  endtask

  task automatic clear_all();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) m_mem[i] = 16'd0;
    for (int i = 0; i < 256; i++) put(i, 16'd0);
  endtask

  task automatic run(input bit poke);
    int cyc;
    @(negedge clk);
    check("R1 reset pc", pc_o, 8'd0);
    check("R1 reset halted", halted, 1'b0);
    check("R1 reset commit", commit_en, 1'b0);
    m_pc = 0; m_halted = 0; m_phase = 0; last_pc_tag = "R1"; n_commits = 0;
    rst = 1'b0;
    cyc = 0;
    compare();
    while (cyc < 2000 && !(m_halted && cyc > 0 && m_phase == 0)) begin
      @(posedge clk);
      step();
      @(negedge clk);
      if (poke) begin
        load_we = (cyc % 3 == 0);
        load_addr = 8'd60 + 8'(cyc % 4);
        load_data = 16'h1234;
      end
      compare();
      cyc++;
      if (m_halted) break;
    end
    load_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      compare();
    end
    if (cyc >= 2000) begin
      errors++;
      $display("FAIL run watchdog");
    end
  endtask

  initial begin
    clear_all();
    put(200, 16'd0); put(201, 16'd7); put(202, 16'd5);
    put(203, 16'd1); put(204, 16'd3);
    put_ins(0, 201, 200, 16'd3);
    put_ins(3, 200, 202, 16'd6);
    put_ins(6, 200, 200, 16'd9);
    put_ins(9, 203, 204, 16'd15);
    put_ins(12, 200, 200, 16'd9);
    put_ins(15, 200, 200, 16'h8000);
    run(1'b0);
    check("R4 loop exit on zero, final pc", pc_o, 8'd15);
    check("R2 commit count", 32'(n_commits), 32'd9);
    check("R7 halted after run", halted, 1'b1);

    clear_all();
    put(60, 16'd10); put(61, 16'd1); put(62, 16'h8000);
    put(63, 16'd1);  put(64, 16'd5);
    put_ins(0, 63, 64, 16'h8000);
    put_ins(3, 60, 8, 16'd6);
    put_ins(6, 200, 200, 16'd20);
    put_ins(10, 61, 62, 16'd13);
    put_ins(13, 200, 200, 16'hFFFF);
    put_ins(20, 200, 200, 16'h8001);
    run(1'b1);
    check("R8 R9 self-modified target reached, final pc", pc_o, 8'd13);
    check("R7 halted stays", halted, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule